// File: doc/BRIEF.md
# Serial Flash Slave Front-End with Pause Control

This block is the serial edge of a NOR flash device. It samples the four-wire serial bus (select, clock, data in) with a fast internal clock, assembles the incoming bits into bytes and hands each byte to an opcode decoder with a strobe. The decoder learns from a flag whether the byte opened the transaction. In the other direction, the decoder raises a read-enable and presents a byte. The front-end takes that byte at each byte boundary and shifts it out most significant bit first. It also provides a separate output-enable for the pad's tri-state driver.

A pause input (active low) can freeze serial traffic in the middle of a transaction. The pause takes effect only while select is active and the serial clock is low. While it is in effect, clock edges and the data input are ignored and the output driver is released. After the pause, shifting continues at the bit where it stopped. The pause has no influence on the self-timed program or erase engine. That engine reports a busy flag, and the busy flag keeps the standby indication low even after select goes inactive. A write-protect pin is resynchronised and passed on as a lock flag. Both the pause and protect pins are active low, so a pin tied high through a pull-up is inactive.

Top module: `spi_flash_frontend`

## Requirements
- R1: After reset, with select high and busy low: standby is 1, the output enable is 0, and there is no byte strobe, incomplete flag or load request.
- R2: Input bits are taken on rising serial clock edges, first bit into bit 7. After every eighth bit, rx_valid pulses for one cycle, with the assembled byte on rx_data.
- R3: rx_cmd is 1 with the first byte of a transaction and 0 with every later byte of the same transaction.
- R4: Clock edges and data arriving while select is high produce no byte. They also leave the next transaction's framing unchanged, so its first byte is complete and flagged as the command.
- R5: A rising select edge clears the bit position. If the bit count is not a multiple of eight at that moment, frame_err pulses for one cycle and the partial byte is dropped. A whole number of bytes produces no pulse.
- R6: While tx_en is 1, a falling serial clock edge at bit position 0 loads tx_data and pulses tx_pull. The other falling edges shift the byte left, and spi_sdo always shows bit 7 of the shift register.
- R7: spi_sdo_oe is 1 only while select is low, tx_en is 1 and no pause is in effect. Otherwise it is 0.
- R8: A low pause input is acted on only while select is low and the serial clock is low. Driving it low while the clock is high has no effect until the clock falls. Release also takes effect with the clock low.
- R9: During a pause, serial clock edges and data are ignored. After release, byte assembly resumes at the paused bit position.
- R10: standby is 1 exactly when select is high and busy is 0. A high busy keeps it 0 after select rises.
- R11: wr_lock is 1 while spi_wp_n is 0 and 0 while spi_wp_n is 1.
- R12: A transaction may begin with the serial clock either low or high. When select falls with the clock high, the first falling edge adds no bit, and the byte is framed correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Serial select, active low |
| spi_sck | input | 1 | Serial clock |
| spi_sdi | input | 1 | Serial data into the device |
| spi_hold_n | input | 1 | Pause request, active low |
| spi_wp_n | input | 1 | Write-protect pin, active low |
| spi_sdo | output | 1 | Serial data out of the device |
| spi_sdo_oe | output | 1 | Output driver enable for spi_sdo |
| tx_en | input | 1 | Decoder is in a data-out phase |
| tx_data | input | DATA_W | Byte to transmit next |
| tx_pull | output | 1 | One-cycle pulse: tx_data was taken |
| rx_valid | output | 1 | One-cycle pulse: a byte is complete |
| rx_data | output | DATA_W | Last complete received byte |
| rx_cmd | output | 1 | Byte on rx_data opened its transaction |
| frame_err | output | 1 | One-cycle pulse: transaction ended mid-byte |
| busy | input | 1 | Self-timed program/erase in progress |
| standby | output | 1 | Device idle and deselected |
| wr_lock | output | 1 | Hardware write lock active |

## Verification
The bench goes after the pause timing. A pause driven while the clock is high must not release the output at once. A design that gates on the raw pin would drop the enable too early. Five clock pulses are driven during a pause. A design that did not freeze the counter would produce a byte, or a corrupted one, from those pulses. Transactions that start with the clock high are run, as are clock pulses with select high and transactions cut off after three bits. These catch framing that counts the mode-3 leading edge, keeps stray bits, or fails to report or clear a partial byte. Read-out of two consecutive bytes checks that each load happens on the boundary edge and not one bit early or late. The busy flag is checked with select high, where a design that ignored it would report standby during a program cycle.

// File: rtl/spife_pkg.sv
package spife_pkg;
  typedef enum logic {
    PAUSE_OFF = 1'b0,
    PAUSE_ON  = 1'b1
  } pause_st_e;

  // positions inside the resynchronised pin vector
  localparam int PIN_CS   = 0;
  localparam int PIN_SCK  = 1;
  localparam int PIN_SDI  = 2;
  localparam int PIN_WP   = 3;
  localparam int PIN_HOLD = 4;
  localparam int PIN_CNT  = 5;
endpackage

// File: rtl/spife_sync.sv
module spife_sync #(
  parameter int               WIDTH   = 1,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= RST_VAL;
    else        stg[0] <= d;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[g] <= RST_VAL;
      else        stg[g] <= stg[g-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spife_pause.sv
module spife_pause
  import spife_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cs_act,
  input  logic sck_lvl,
  input  logic hold_n_lvl,
  output logic hold_act
);
  pause_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (!cs_act) begin
      st_d = PAUSE_OFF;
    end else if (!sck_lvl) begin
      // both entry and exit are taken only with the serial clock low
      if (st_q == PAUSE_OFF && !hold_n_lvl) st_d = PAUSE_ON;
      if (st_q == PAUSE_ON  &&  hold_n_lvl) st_d = PAUSE_OFF;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= PAUSE_OFF;
    else        st_q <= st_d;
  end

  assign hold_act = (st_q == PAUSE_ON);
endmodule

// File: rtl/spife_rx.sv
module spife_rx #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              cs_rise,
  input  logic              cs_fall,
  input  logic              sck_rise,
  input  logic              hold_act,
  input  logic              sdi,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_cmd,
  output logic              frame_err
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              first_q, first_d;
  logic              vld_q, vld_d;
  logic [DATA_W-1:0] dat_q, dat_d;
  logic              cmd_q, cmd_d;
  logic              err_q, err_d;
  logic              take_bit;
  logic [DATA_W-1:0] sh_next;

  assign take_bit = cs_act && sck_rise && !hold_act;
  assign sh_next  = {sh_q[DATA_W-2:0], sdi};

  always_comb begin
    sh_d    = sh_q;
    cnt_d   = cnt_q;
    first_d = first_q;
    vld_d   = 1'b0;
    dat_d   = dat_q;
    cmd_d   = cmd_q;
    err_d   = 1'b0;
    if (cs_rise || cs_fall) begin
      cnt_d   = '0;
      first_d = 1'b1;
      err_d   = cs_rise && (cnt_q != '0);
    end else if (take_bit) begin
      sh_d = sh_next;
      if (cnt_q == LAST_BIT) begin
        cnt_d   = '0;
        vld_d   = 1'b1;
        dat_d   = sh_next;
        cmd_d   = first_q;
        first_d = 1'b0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      cnt_q   <= '0;
      first_q <= 1'b1;
      vld_q   <= 1'b0;
      dat_q   <= '0;
      cmd_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      sh_q    <= sh_d;
      cnt_q   <= cnt_d;
      first_q <= first_d;
      vld_q   <= vld_d;
      dat_q   <= dat_d;
      cmd_q   <= cmd_d;
      err_q   <= err_d;
    end
  end

  assign bit_cnt   = cnt_q;
  assign rx_valid  = vld_q;
  assign rx_data   = dat_q;
  assign rx_cmd    = cmd_q;
  assign frame_err = err_q;
endmodule

// File: rtl/spife_tx.sv
module spife_tx #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              sck_fall,
  input  logic              hold_act,
  input  logic [CNT_W-1:0]  bit_cnt,
  input  logic              tx_en,
  input  logic [DATA_W-1:0] tx_data,
  output logic              sdo,
  output logic              tx_pull
);
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              pull_q, pull_d;
  logic              step;

  assign step = cs_act && sck_fall && !hold_act && tx_en;

  always_comb begin
    sh_d   = sh_q;
    pull_d = 1'b0;
    if (step) begin
      if (bit_cnt == '0) begin
        sh_d   = tx_data;
        pull_d = 1'b1;
      end else begin
        sh_d = {sh_q[DATA_W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      pull_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      pull_q <= pull_d;
    end
  end

  assign sdo     = sh_q[DATA_W-1];
  assign tx_pull = pull_q;
endmodule

// File: rtl/spi_flash_frontend.sv
module spi_flash_frontend
  import spife_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_cs_n,
  input  logic              spi_sck,
  input  logic              spi_sdi,
  input  logic              spi_hold_n,
  input  logic              spi_wp_n,
  output logic              spi_sdo,
  output logic              spi_sdo_oe,
  input  logic              tx_en,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_pull,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_cmd,
  output logic              frame_err,
  input  logic              busy,
  output logic              standby,
  output logic              wr_lock
);
  localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam logic [PIN_CNT-1:0] PIN_IDLE = PIN_CNT'(5'b11001);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  // pin resynchronisation
  logic [PIN_CNT-1:0] pins_raw, pins_s;
  assign pins_raw = {spi_hold_n, spi_wp_n, spi_sdi, spi_sck, spi_cs_n};

  spife_sync #(
    .WIDTH  (PIN_CNT),
    .STAGES (SYNC_STAGES),
    .RST_VAL(PIN_IDLE)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_int_n),
    .d    (pins_raw),
    .q    (pins_s)
  );

  logic cs_act, sck_s, sdi_s, hold_n_s, wp_n_s;
  assign cs_act   = !pins_s[PIN_CS];
  assign sck_s    = pins_s[PIN_SCK];
  assign sdi_s    = pins_s[PIN_SDI];
  assign wp_n_s   = pins_s[PIN_WP];
  assign hold_n_s = pins_s[PIN_HOLD];

  // edge detection on the resynchronised levels
  logic sck_prev_q, cs_prev_q;
  logic sck_rise, sck_fall, cs_rise, cs_fall;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      sck_prev_q <= 1'b0;
      cs_prev_q  <= 1'b0;
    end else begin
      sck_prev_q <= sck_s;
      cs_prev_q  <= cs_act;
    end
  end

  assign sck_rise = sck_s && !sck_prev_q;
  assign sck_fall = !sck_s && sck_prev_q;
  assign cs_fall  = cs_act && !cs_prev_q;
  assign cs_rise  = !cs_act && cs_prev_q;

  logic             hold_act;
  logic [CNT_W-1:0] bit_cnt;

  spife_pause u_pause (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .cs_act    (cs_act),
    .sck_lvl   (sck_s),
    .hold_n_lvl(hold_n_s),
    .hold_act  (hold_act)
  );

  spife_rx #(
    .DATA_W(DATA_W),
    .CNT_W (CNT_W)
  ) u_rx (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .cs_act   (cs_act),
    .cs_rise  (cs_rise),
    .cs_fall  (cs_fall),
    .sck_rise (sck_rise),
    .hold_act (hold_act),
    .sdi      (sdi_s),
    .bit_cnt  (bit_cnt),
    .rx_valid (rx_valid),
    .rx_data  (rx_data),
    .rx_cmd   (rx_cmd),
    .frame_err(frame_err)
  );

  spife_tx #(
    .DATA_W(DATA_W),
    .CNT_W (CNT_W)
  ) u_tx (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .cs_act  (cs_act),
    .sck_fall(sck_fall),
    .hold_act(hold_act),
    .bit_cnt (bit_cnt),
    .tx_en   (tx_en),
    .tx_data (tx_data),
    .sdo     (spi_sdo),
    .tx_pull (tx_pull)
  );

  assign spi_sdo_oe = cs_act && tx_en && !hold_act;
  assign standby    = !cs_act && !busy;
  assign wr_lock    = !wp_n_s;
endmodule

// File: rtl/spife_checker.sv
module spife_checker #(
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_act,
  input logic             sck_lvl,
  input logic             hold_act,
  input logic [CNT_W-1:0] bit_cnt,
  input logic             rx_valid,
  input logic             frame_err,
  input logic             sdo_oe,
  input logic             busy,
  input logic             standby
);
  AST_BYTE_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R2

  AST_IDLE_COUNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> (bit_cnt == '0)); // R4

  AST_ERR_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> !frame_err); // R5

  AST_PAUSE_DRIVER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    hold_act |-> !sdo_oe); // R7

  AST_PAUSE_ENTRY_LOW_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_act) |-> $past(!sck_lvl && cs_act)); // R8

  AST_PAUSE_COUNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_act && $past(hold_act)) |-> $stable(bit_cnt)); // R9

  AST_BUSY_BLOCKS_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !standby); // R10
endmodule

bind spi_flash_frontend spife_checker #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs_act   (cs_act),
  .sck_lvl  (sck_s),
  .hold_act (hold_act),
  .bit_cnt  (bit_cnt),
  .rx_valid (rx_valid),
  .frame_err(frame_err),
  .sdo_oe   (spi_sdo_oe),
  .busy     (busy),
  .standby  (standby)
);

// File: tb/spi_flash_frontend_test.sv
module spi_flash_frontend_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam int DW         = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cs_n, sck, sdi, hold_n, wp_n, tx_en, busy;
  logic [DW-1:0] tx_data;
  logic          sdo, sdo_oe, tx_pull, rx_valid, rx_cmd, frame_err, standby, wr_lock;
  logic [DW-1:0] rx_data;

  int checks = 0;
  int errors = 0;
  int rx_cnt = 0;
  int err_cnt = 0;
  int pull_cnt = 0;
  logic [DW-1:0] last_byte = '0;
  logic          last_cmd = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_flash_frontend #(.DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n),
    .spi_cs_n(cs_n), .spi_sck(sck), .spi_sdi(sdi),
    .spi_hold_n(hold_n), .spi_wp_n(wp_n),
    .spi_sdo(sdo), .spi_sdo_oe(sdo_oe),
    .tx_en(tx_en), .tx_data(tx_data), .tx_pull(tx_pull),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_cmd(rx_cmd),
    .frame_err(frame_err), .busy(busy), .standby(standby), .wr_lock(wr_lock)
  );

  // port monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_valid) begin
        rx_cnt    <= rx_cnt + 1;
        last_byte <= rx_data;
        last_cmd  <= rx_cmd;
      end
      if (frame_err) err_cnt  <= err_cnt + 1;
      if (tx_pull)   pull_cnt <= pull_cnt + 1;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bit_out(input logic b);
    sck = 1'b0; sdi = b; wait_cyc(HALF);
    sck = 1'b1; wait_cyc(HALF);
  endtask

  task automatic byte_out(input logic [DW-1:0] v);
    for (int i = DW-1; i >= 0; i--) bit_out(v[i]);
  endtask

  task automatic start_low();
    sck = 1'b0; wait_cyc(HALF);
    cs_n = 1'b0; wait_cyc(HALF);
  endtask

  task automatic start_high();
    sck = 1'b1; wait_cyc(HALF);
    cs_n = 1'b0; wait_cyc(HALF);
  endtask

  task automatic finish_xfer();
    wait_cyc(HALF);
    cs_n = 1'b1; wait_cyc(HALF);
  endtask

  task automatic t_reset();
    chk("R1 standby", int'(standby), 1);
    chk("R1 oe", int'(sdo_oe), 0);
    chk("R1 no strobes", rx_cnt + err_cnt + pull_cnt, 0);
    chk("R11 lock idle", int'(wr_lock), 0);
  endtask

  task automatic t_protect();
    wp_n = 1'b0; wait_cyc(HALF);
    chk("R11 lock on", int'(wr_lock), 1);
    wp_n = 1'b1; wait_cyc(HALF);
    chk("R11 lock off", int'(wr_lock), 0);
  endtask

  task automatic t_bytes();
    int c0 = rx_cnt;
    start_low();
    byte_out(8'h9F);
    chk("R2 count", rx_cnt - c0, 1);
    chk("R2 byte", int'(last_byte), 'h9F);
    chk("R3 first cmd", int'(last_cmd), 1);
    byte_out(8'h12);
    chk("R2 byte2", int'(last_byte), 'h12);
    chk("R3 later not cmd", int'(last_cmd), 0);
    byte_out(8'h81);
    chk("R2 byte3", int'(last_byte), 'h81);
    finish_xfer();
    chk("R5 whole bytes no err", err_cnt, 0);
  endtask

  task automatic t_deselected();
    int c0 = rx_cnt;
    int e0 = err_cnt;
    sck = 1'b0; wait_cyc(HALF);
    for (int i = 0; i < 5; i++) bit_out(1'b1);
    chk("R4 no byte while deselected", rx_cnt - c0, 0);
    start_low();
    byte_out(8'h3C);
    finish_xfer();
    chk("R4 next byte", int'(last_byte), 'h3C);
    chk("R4 next is cmd", int'(last_cmd), 1);
    chk("R4 no err", err_cnt - e0, 0);
  endtask

  task automatic t_partial();
    int c0 = rx_cnt;
    int e0 = err_cnt;
    start_low();
    for (int i = 0; i < 3; i++) bit_out(1'b1);
    finish_xfer();
    chk("R5 partial flagged", err_cnt - e0, 1);
    chk("R5 partial dropped", rx_cnt - c0, 0);
    start_low();
    byte_out(8'h66);
    finish_xfer();
    chk("R5 framing cleared", int'(last_byte), 'h66);
    chk("R5 cmd after partial", int'(last_cmd), 1);
  endtask

  task automatic read_byte(input logic [DW-1:0] exp, input string tag);
    for (int i = DW-1; i >= 0; i--) begin
      sck = 1'b0; sdi = 1'b0; wait_cyc(HALF);
      chk(tag, int'(sdo), int'(exp[i]));
      chk("R7 oe during read", int'(sdo_oe), 1);
      sck = 1'b1; wait_cyc(HALF);
    end
  endtask

  task automatic t_read();
    int p0;
    start_low();
    chk("R7 oe off without tx_en", int'(sdo_oe), 0);
    byte_out(8'h0B);
    tx_data = 8'hA5; tx_en = 1'b1;
    p0 = pull_cnt;
    read_byte(8'hA5, "R6 first byte bit");
    chk("R6 one load", pull_cnt - p0, 1);
    tx_data = 8'h3C;
    read_byte(8'h3C, "R6 second byte bit");
    chk("R6 two loads", pull_cnt - p0, 2);
    finish_xfer();
    chk("R7 oe off deselected", int'(sdo_oe), 0);
    tx_en = 1'b0;
  endtask

  task automatic t_pause_entry();
    tx_en = 1'b1; tx_data = 8'h00;
    start_high();
    chk("R7 oe on", int'(sdo_oe), 1);
    hold_n = 1'b0; wait_cyc(HALF);
    chk("R8 no pause with clock high", int'(sdo_oe), 1);
    sck = 1'b0; wait_cyc(HALF);
    chk("R8 pause once clock low", int'(sdo_oe), 0);
    hold_n = 1'b1; wait_cyc(HALF);
    chk("R8 released", int'(sdo_oe), 1);
    finish_xfer();
    tx_en = 1'b0;
  endtask

  task automatic t_pause_freeze();
    int c0 = rx_cnt;
    int e0 = err_cnt;
    logic [DW-1:0] v = 8'hB6;
    start_low();
    tx_en = 1'b1;
    for (int i = DW-1; i >= 4; i--) bit_out(v[i]);
    sck = 1'b0; wait_cyc(HALF);
    hold_n = 1'b0; wait_cyc(HALF);
    for (int i = 0; i < 5; i++) begin
      sdi = i[0]; sck = 1'b1; wait_cyc(HALF);
      sck = 1'b0; wait_cyc(HALF);
    end
    chk("R9 no byte from paused clocks", rx_cnt - c0, 0);
    chk("R7 oe off in pause", int'(sdo_oe), 0);
    hold_n = 1'b1; wait_cyc(HALF);
    tx_en = 1'b0;
    for (int i = 3; i >= 0; i--) bit_out(v[i]);
    finish_xfer();
    chk("R9 resumed byte", int'(last_byte), 'hB6);
    chk("R9 single byte", rx_cnt - c0, 1);
    chk("R9 no err", err_cnt - e0, 0);
  endtask

  task automatic t_mode3();
    int c0 = rx_cnt;
    int e0 = err_cnt;
    start_high();
    byte_out(8'h5A);
    finish_xfer();
    chk("R12 byte", int'(last_byte), 'h5A);
    chk("R12 cmd", int'(last_cmd), 1);
    chk("R12 count", rx_cnt - c0, 1);
    chk("R12 no err", err_cnt - e0, 0);
  endtask

  task automatic t_standby();
    busy = 1'b1; wait_cyc(HALF);
    chk("R10 busy blocks standby", int'(standby), 0);
    busy = 1'b0; wait_cyc(HALF);
    chk("R10 standby back", int'(standby), 1);
    sck = 1'b0; cs_n = 1'b0; wait_cyc(HALF);
    chk("R10 selected not standby", int'(standby), 0);
    busy = 1'b1; cs_n = 1'b1; wait_cyc(HALF);
    chk("R10 held off after deselect", int'(standby), 0);
    busy = 1'b0; wait_cyc(HALF);
    chk("R10 standby after busy", int'(standby), 1);
  endtask

  logic done = 1'b0;

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; sdi = 1'b0;
    hold_n = 1'b1; wp_n = 1'b1; tx_en = 1'b0; busy = 1'b0; tx_data = '0;
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(8);
    t_reset();
    t_protect();
    t_bytes();
    t_deselected();
    t_partial();
    t_read();
    t_pause_entry();
    t_pause_freeze();
    t_mode3();
    t_standby();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule